// File: doc/BRIEF.md
# Integer-Ratio Clock Divider with Edge-Aligned Data Crossing

This block takes a fast clock and produces a slow clock at an integer fraction of its frequency. Because the slow clock is a register output of the fast domain, every slow rising edge falls on a fast rising edge. A registered flag, `slow_edge_next`, marks the one fast cycle in each slow period whose closing fast edge is also a slow rising edge. Logic in either domain can use this flag to exchange data across the boundary without synchronizer flops: a value that changes only at that edge is stable for the whole slow period.

A small FIFO carries words across the boundary and is gated by the flag. In the fast-to-slow variant, the fast producer can hand over a word only in a flagged cycle, and the slow consumer reads at slow edges. In the slow-to-fast variant, the slow producer writes at slow edges and the fast consumer may read on any fast edge. Both sides use valid/ready. A transfer takes place at the fast edge that ends a cycle in which both valid and ready are high. `in_ready` falls whenever the FIFO is full or the write side is not at a slow edge. `out_valid` is high whenever the FIFO holds a word. The producer must hold `in_data` and `in_valid` until the transfer. The consumer may raise `out_ready` at any time. The ratio must be at least 2.

Top module: `ratio_clock_bridge`

## Requirements
- R1: `clk_slow` repeats every DIV_RATIO fast cycles. After each rising edge it stays high for floor(DIV_RATIO/2) fast cycles and is low for the rest of the period.
- R2: Reset (synchronous, active high) holds `clk_slow` low. The first rising edge of `clk_slow` comes at the DIV_RATIO-th fast rising edge after reset is released.
- R3: `slow_edge_next` is high for exactly one fast cycle per slow period: the cycle that ends with a `clk_slow` rising edge. It is low during reset and in every other cycle.
- R4: `in_ready` is high only in cycles where `slow_edge_next` is high and the FIFO holds fewer than DEPTH (default 4) words. This holds in both variants.
- R5: In the fast-to-slow variant (DIRECTION = XFER_FAST_TO_SLOW, value 0), a word is removed only at a slow rising edge that ends a cycle with `out_valid` and `out_ready` both high. `out_valid` and `out_data` change only at slow rising edges.
- R6: In the fast-to-slow variant, a word accepted into an empty FIFO appears on `out_data` with `out_valid` high immediately after the slow edge at which it was accepted.
- R7: Words leave in the order they were accepted. While DEPTH words are held, `in_ready` stays low.
- R8: When the FIFO is full, a removal at a slow edge does not open room for a write at that same edge. The offered word is refused and not stored.
- R9: While the FIFO is empty, `out_valid` is low and `out_ready` has no effect. A word written later comes out unchanged.
- R10: In the slow-to-fast variant (DIRECTION = XFER_SLOW_TO_FAST, value 1), a word accepted at a slow edge is on `out_data` with `out_valid` high right after that edge. The fast side may remove words on any fast edge.
- R11: While reset is applied, `in_ready`, `out_valid`, `clk_slow` and `slow_edge_next` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast clock; every register is clocked by it |
| rst | input | 1 | Synchronous reset, active high |
| clk_slow | output | 1 | Divided clock, registered |
| slow_edge_next | output | 1 | High in the fast cycle that precedes a slow rising edge |
| in_valid | input | 1 | Producer offers a word |
| in_ready | output | 1 | FIFO accepts a word at the coming edge |
| in_data | input | DATA_W | Offered word |
| out_valid | output | 1 | FIFO holds a word |
| out_ready | input | 1 | Consumer takes the head word |
| out_data | output | DATA_W | Head word of the FIFO |

## Verification
The bench builds three copies of the block. The first uses a ratio of 12 in the fast-to-slow variant and carries the FIFO ordering, full, empty and same-edge tests at depth 4 with 8-bit words. The second uses a ratio of 5 in the slow-to-fast variant; the odd ratio tests the 2-high/3-low split and allows reads between slow edges. The third uses a ratio of 48 and only checks the divider waveform, including the long wait before the first slow rising edge.

// File: rtl/rcb_pkg.sv
package rcb_pkg;
  typedef enum logic {
    XFER_FAST_TO_SLOW = 1'b0,
    XFER_SLOW_TO_FAST = 1'b1
  } xfer_dir_e;
endpackage

// File: rtl/rcb_divider.sv
module rcb_divider #(
  parameter int unsigned RATIO = 12
) (
  input  logic clk,
  input  logic rst,
  output logic slow_clk,
  output logic edge_next
);
  localparam int unsigned CNT_W    = (RATIO > 2) ? $clog2(RATIO) : 1;
  localparam int unsigned HIGH_LEN = RATIO / 2;
  localparam logic [CNT_W-1:0] LAST     = CNT_W'(RATIO - 1);
  localparam logic [CNT_W-1:0] HIGH_END = CNT_W'(HIGH_LEN);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             wrap;

  // counter 0..RATIO-1; run flag keeps the slow clock low until the first wrap
  always_comb begin
    wrap  = (cnt_q == LAST);
    cnt_d = wrap ? '0 : cnt_q + CNT_W'(1);
    run_d = run_q | wrap;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      run_q     <= 1'b0;
      slow_clk  <= 1'b0;
      edge_next <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      run_q     <= run_d;
      slow_clk  <= run_d && (cnt_d < HIGH_END);
      edge_next <= (cnt_d == LAST);
    end
  end

  p_ready_single_r3: assert property (@(posedge clk) disable iff (rst)
    edge_next |=> !edge_next);
  p_ready_then_rise_r3: assert property (@(posedge clk) disable iff (rst)
    edge_next |=> slow_clk);
  p_rise_after_ready_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(slow_clk) |-> $past(edge_next));
endmodule

// File: rtl/rcb_fifo.sv
module rcb_fifo #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pop,
  output logic [DATA_W-1:0] rdata,
  output logic              full,
  output logic              empty
);
  localparam int unsigned PTR_W = (DEPTH > 2) ? $clog2(DEPTH) : 1;
  localparam int unsigned USE_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [USE_W-1:0] USE_FULL = USE_W'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [USE_W-1:0]  used;

  always_comb begin
    full  = (used == USE_FULL);
    empty = (used == '0);
    rdata = mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      used   <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + PTR_W'(1);
      if (pop)  rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + PTR_W'(1);
      case ({push, pop})
        2'b10:   used <= used + USE_W'(1);
        2'b01:   used <= used - USE_W'(1);
        default: used <= used;
      endcase
    end
  end

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    full |-> !push);
  p_no_underflow_r9: assert property (@(posedge clk) disable iff (rst)
    empty |-> !pop);
  p_full_holds_r8: assert property (@(posedge clk) disable iff (rst)
    (full && !pop) |=> full);
endmodule

// File: rtl/ratio_clock_bridge.sv
module ratio_clock_bridge #(
  parameter int unsigned        DIV_RATIO = 12,
  parameter int unsigned        DATA_W    = 8,
  parameter int unsigned        DEPTH     = 4,
  parameter rcb_pkg::xfer_dir_e DIRECTION = rcb_pkg::XFER_FAST_TO_SLOW
) (
  input  logic              clk_fast,
  input  logic              rst,
  output logic              clk_slow,
  output logic              slow_edge_next,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  logic full, empty, push, pop;

  rcb_divider #(.RATIO(DIV_RATIO)) u_div (
    .clk       (clk_fast),
    .rst       (rst),
    .slow_clk  (clk_slow),
    .edge_next (slow_edge_next)
  );

  // slow-domain logic runs on clk_fast, enabled in the flagged cycle
  always_comb begin
    in_ready  = slow_edge_next && !full;
    push      = in_valid && in_ready;
    out_valid = !empty;
  end

  generate
    if (DIRECTION == rcb_pkg::XFER_FAST_TO_SLOW) begin : g_to_slow
      always_comb pop = slow_edge_next && out_ready && !empty;

      p_out_only_at_edge_r5: assert property (@(posedge clk_fast) disable iff (rst)
        !$past(slow_edge_next) |-> ($stable(out_valid) && $stable(out_data)));
    end else begin : g_to_fast
      always_comb pop = out_ready && !empty;

      p_fill_at_edge_r10: assert property (@(posedge clk_fast) disable iff (rst)
        $rose(out_valid) |-> $past(slow_edge_next));
    end
  endgenerate

  rcb_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk_fast),
    .rst   (rst),
    .push  (push),
    .wdata (in_data),
    .pop   (pop),
    .rdata (out_data),
    .full  (full),
    .empty (empty)
  );

  p_accept_at_edge_r4: assert property (@(posedge clk_fast) disable iff (rst)
    (in_valid && in_ready) |=> $rose(clk_slow));
endmodule

// File: tb/test_ratio_clock_bridge.sv
module test_ratio_clock_bridge;
  localparam int W  = 8;
  localparam int NA = 12;
  localparam int NB = 5;
  localparam int NC = 48;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic a_slow, a_rdy, a_in_valid, a_in_ready, a_out_valid, a_out_ready;
  logic [W-1:0] a_in_data, a_out_data;
  logic b_slow, b_rdy, b_in_valid, b_in_ready, b_out_valid, b_out_ready;
  logic [W-1:0] b_in_data, b_out_data;
  logic c_slow, c_rdy, c_in_ready, c_out_valid;
  logic [W-1:0] c_out_data;

  ratio_clock_bridge #(.DIV_RATIO(NA), .DATA_W(W), .DEPTH(4),
                       .DIRECTION(rcb_pkg::XFER_FAST_TO_SLOW)) i_ratio_clock_bridge (
    .clk_fast(clk), .rst(rst), .clk_slow(a_slow), .slow_edge_next(a_rdy),
    .in_valid(a_in_valid), .in_ready(a_in_ready), .in_data(a_in_data),
    .out_valid(a_out_valid), .out_ready(a_out_ready), .out_data(a_out_data));

  ratio_clock_bridge #(.DIV_RATIO(NB), .DATA_W(W), .DEPTH(4),
                       .DIRECTION(rcb_pkg::XFER_SLOW_TO_FAST)) i_ratio_clock_bridge_s2f (
    .clk_fast(clk), .rst(rst), .clk_slow(b_slow), .slow_edge_next(b_rdy),
    .in_valid(b_in_valid), .in_ready(b_in_ready), .in_data(b_in_data),
    .out_valid(b_out_valid), .out_ready(b_out_ready), .out_data(b_out_data));

  ratio_clock_bridge #(.DIV_RATIO(NC), .DATA_W(W), .DEPTH(4),
                       .DIRECTION(rcb_pkg::XFER_FAST_TO_SLOW)) i_ratio_clock_bridge_48 (
    .clk_fast(clk), .rst(rst), .clk_slow(c_slow), .slow_edge_next(c_rdy),
    .in_valid(1'b0), .in_ready(c_in_ready), .in_data('0),
    .out_valid(c_out_valid), .out_ready(1'b0), .out_data(c_out_data));

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int r5_bad = 0;
  int r4_bad = 0;
  bit done   = 1'b0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // advance one fast cycle, sampling on the falling edge
  task automatic step();
    logic pr, pv;
    logic [W-1:0] pd;
    pr = a_rdy; pv = a_out_valid; pd = a_out_data;
    @(negedge clk);
    cyc++;
    if (!pr && (a_out_valid !== pv || a_out_data !== pd)) r5_bad++;
    if ((a_in_ready && !a_rdy) || (b_in_ready && !b_rdy)) r4_bad++;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    a_in_valid = 0; a_out_ready = 0; a_in_data = '0;
    b_in_valid = 0; b_out_ready = 0; b_in_data = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(!a_slow && !b_slow && !c_slow, "R11", "clk_slow in reset", int'(a_slow|b_slow|c_slow), 0);
    check(!a_rdy && !b_rdy && !c_rdy, "R11", "ready flag in reset", int'(a_rdy|b_rdy|c_rdy), 0);
    check(!a_in_ready && !b_in_ready && !c_in_ready, "R11", "in_ready in reset",
          int'(a_in_ready|b_in_ready|c_in_ready), 0);
    check(!a_out_valid && !b_out_valid && !c_out_valid, "R11", "out_valid in reset",
          int'(a_out_valid|b_out_valid|c_out_valid), 0);
    rst = 1'b0;
    cyc = 0;
  endtask

  function automatic bit exp_slow(int n, int c);
    return (c >= n) && (((c - n) % n) < (n / 2));
  endfunction

  task automatic t_divider();
    int r1 [3];
    int r2 [3];
    int r3 [3];
    for (int k = 0; k < 3; k++) begin r1[k] = 0; r2[k] = 0; r3[k] = 0; end
    for (int c = 0; c <= 150; c++) begin
      if (c > 0) step();
      for (int k = 0; k < 3; k++) begin
        int n;
        logic s, r;
        n = (k == 0) ? NA : (k == 1) ? NB : NC;
        s = (k == 0) ? a_slow : (k == 1) ? b_slow : c_slow;
        r = (k == 0) ? a_rdy  : (k == 1) ? b_rdy  : c_rdy;
        if (s !== exp_slow(n, c)) begin
          if (c <= n) r2[k]++; else r1[k]++;
        end
        if (r !== ((c % n) == n - 1)) r3[k]++;
      end
    end
    for (int k = 0; k < 3; k++) begin
      check(r1[k] == 0, "R1", $sformatf("slow waveform mismatches, instance %0d", k), r1[k], 0);
      check(r2[k] == 0, "R2", $sformatf("first rise mismatches, instance %0d", k), r2[k], 0);
      check(r3[k] == 0, "R3", $sformatf("ready flag mismatches, instance %0d", k), r3[k], 0);
    end
  endtask

  task automatic a_push(logic [W-1:0] d);
    bit acc;
    a_in_valid = 1'b1; a_in_data = d;
    do begin
      acc = a_in_ready;
      if (acc) check(a_rdy == 1'b1, "R4", "accept only in flagged cycle", int'(a_rdy), 1);
      step();
    end while (!acc);
    a_in_valid = 1'b0;
    check(a_slow == 1'b1, "R6", "accept edge is slow rising edge", int'(a_slow), 1);
    check(a_out_valid == 1'b1, "R6", "out_valid after accept", int'(a_out_valid), 1);
  endtask

  task automatic a_pop(logic [W-1:0] exp);
    bit go;
    logic [W-1:0] got;
    a_out_ready = 1'b1;
    do begin
      go  = a_rdy && a_out_valid;
      got = a_out_data;
      step();
    end while (!go);
    a_out_ready = 1'b0;
    check(got == exp, "R7", "word order", int'(got), int'(exp));
  endtask

  task automatic t_f2s_basic();
    a_push(8'h11);
    check(a_out_data == 8'h11, "R6", "first word visible after slow edge", int'(a_out_data), 'h11);
    a_push(8'h22);
    a_push(8'h33);
    a_pop(8'h11);
    a_pop(8'h22);
    a_pop(8'h33);
    check(a_out_valid == 1'b0, "R5", "empty after drain", int'(a_out_valid), 0);
  endtask

  task automatic t_f2s_full();
    int hi;
    a_push(8'hA1); a_push(8'hA2); a_push(8'hA3); a_push(8'hA4);
    hi = 0;
    a_in_valid = 1'b1; a_in_data = 8'hA5;
    for (int i = 0; i < 2 * NA; i++) begin
      step();
      if (a_in_ready) hi++;
    end
    check(hi == 0, "R7", "in_ready while full", hi, 0);
    check(a_out_data == 8'hA1, "R7", "head held while full", int'(a_out_data), 'hA1);
    a_out_ready = 1'b1;
    while (!a_rdy) step();
    check(a_in_ready == 1'b0, "R8", "in_ready at edge with pop pending", int'(a_in_ready), 0);
    step();
    a_out_ready = 1'b0;
    a_in_valid  = 1'b0;
    check(a_out_data == 8'hA2, "R8", "head after same-edge pop", int'(a_out_data), 'hA2);
    a_pop(8'hA2); a_pop(8'hA3); a_pop(8'hA4);
    check(a_out_valid == 1'b0, "R8", "refused word not stored", int'(a_out_valid), 0);
  endtask

  task automatic t_f2s_empty();
    int seen;
    seen = 0;
    a_out_ready = 1'b1;
    for (int i = 0; i < 2 * NA + 1; i++) begin
      step();
      if (a_out_valid) seen++;
    end
    a_out_ready = 1'b0;
    check(seen == 0, "R9", "out_valid while empty", seen, 0);
    a_push(8'h5C);
    check(a_out_data == 8'h5C, "R9", "word after empty reads", int'(a_out_data), 'h5C);
    a_pop(8'h5C);
    check(a_out_valid == 1'b0, "R9", "empty after single word", int'(a_out_valid), 0);
    check(r5_bad == 0, "R5", "output changes off slow edge", r5_bad, 0);
    check(r4_bad == 0, "R4", "in_ready outside flagged cycle", r4_bad, 0);
  endtask

  task automatic b_push(logic [W-1:0] d);
    bit acc;
    b_in_valid = 1'b1; b_in_data = d;
    do begin
      acc = b_in_ready;
      step();
    end while (!acc);
    b_in_valid = 1'b0;
    check(b_out_valid == 1'b1, "R10", "s2f out_valid after accept", int'(b_out_valid), 1);
  endtask

  task automatic t_s2f();
    b_push(8'h71);
    check(b_out_data == 8'h71, "R10", "s2f first word", int'(b_out_data), 'h71);
    b_push(8'h72);
    check(b_rdy == 1'b0, "R10", "pop cycle is not flagged", int'(b_rdy), 0);
    check(b_in_ready == 1'b0, "R4", "s2f in_ready outside flagged cycle", int'(b_in_ready), 0);
    b_out_ready = 1'b1;
    step();
    check(b_out_valid == 1'b1 && b_out_data == 8'h72, "R10", "s2f pop between slow edges",
          int'(b_out_data), 'h72);
    check(b_rdy == 1'b0, "R10", "second pop cycle is not flagged", int'(b_rdy), 0);
    step();
    b_out_ready = 1'b0;
    check(b_out_valid == 1'b0, "R10", "s2f empty after two fast pops", int'(b_out_valid), 0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    t_divider();
    t_f2s_basic();
    t_f2s_full();
    t_f2s_empty();
    t_s2f();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule